// File: doc/BRIEF.md
# Hardware Return Address Stack

This block keeps the return addresses of a small processor core in dedicated storage, apart from program and data memory. When the core takes a subroutine call or accepts an interrupt, it raises a push request carrying the return program counter. When it executes a return, it raises a pop request and takes the restore address from the block in the same cycle. The storage holds 31 entries of 21 bits. A 5-bit pointer selects the current top entry. Pointer value 0 is an empty position with no storage behind it, and it is the value after reset.

Software reaches the stack through four byte-wide registers chosen by a 2-bit select:
- three views of the top entry: its upper 5 bits, its middle byte and its low byte;
- one combined pointer/status register.

With these, a handler can copy the top entry out to a software stack and later put it back. It can also move the pointer directly. Stack full is reported as a status level. Overflow and underflow are reported as sticky flags, which stay set until software clears them.

A level state machine follows the pointer and has three states: `LVL_EMPTY`, `LVL_PARTIAL` and `LVL_FULL`. Its transitions are:
- `LVL_EMPTY` goes to `LVL_PARTIAL` on a push.
- `LVL_PARTIAL` goes to `LVL_FULL` on a push at pointer 30.
- `LVL_PARTIAL` goes to `LVL_EMPTY` on a pop at pointer 1.
- `LVL_FULL` goes to `LVL_PARTIAL` on a pop.
- A software pointer write moves from any state to the state that matches the written pointer.

Top module: `ras_unit`

## Requirements
- R1: After reset the pointer is 0, all flags are clear, and the pointer/status register (select 3) reads 0x00.
- R2: A push that is accepted first increments the pointer, then stores `push_pc` in the entry the new pointer selects; that entry becomes the top entry.
- R3: While `pop_req` is high, `pop_pc` shows the entry at the current pointer in the same cycle. An accepted pop decrements the pointer at the next clock edge.
- R4: Select 0 reads the top entry's bits 20:16 as `{3'b000, bits}`, select 1 reads bits 15:8 and select 2 reads bits 7:0. A write to one of these selects replaces only that field of the top entry; select 0 takes `sw_wdata[4:0]`.
- R5: Select 3 reads `{overflow, underflow, full, pointer[4:0]}`, with bit 7 overflow, bit 6 underflow, bit 5 full and bits 4:0 the pointer. A write to select 3 loads the pointer from `sw_wdata[4:0]`.
- R6: `stk_full` and status bit 5 are high exactly while the pointer is 31.
- R7: A push at pointer 31 sets overflow, leaves the pointer at 31 and changes no stored entry.
- R8: A pop at pointer 0 returns 0 on `pop_pc`, sets underflow and leaves the pointer at 0.
- R9: While the pointer is 0, selects 0 to 2 read 0x00 and writes to them have no effect.
- R10: A software write in the same cycle as a push or pop wins, and the push or pop is ignored. A push in the same cycle as a pop wins, and the pop is ignored.
- R11: Overflow and underflow stay set until a write to select 3 with `sw_wdata[7]` (for overflow) or `sw_wdata[6]` (for underflow) at 0. Writing 1 in those bits keeps the flag as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Push the return address |
| push_pc | input | 21 | Return address to store |
| pop_req | input | 1 | Pop the top entry |
| pop_pc | output | 21 | Restore address (top entry, or 0 when empty) |
| sw_sel | input | 2 | Register select: 0 upper, 1 high, 2 low, 3 pointer/status |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write byte |
| sw_rdata | output | 8 | Software read byte for `sw_sel` |
| stk_full | output | 1 | Pointer is at 31 |
| stk_ovf | output | 1 | Sticky overflow flag |
| stk_unf | output | 1 | Sticky underflow flag |

## Verification
The stack is exercised with several input patterns:
- Nested push/pop sequences whose address values differ in every byte. These show whether the entry is written before or after the pointer moves.
- A fill to 31 followed by an extra push. This separates a full level from overflow and proves that the stored entries survive.
- Draining past empty. This shows the zero restore address and the underflow flag.
- Push, pop and software writes raised in the same cycle. These reveal the priority order.
- Writes to the status register with the keep bits set and then cleared. These separate sticky flag behaviour from a plain load.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        LVL_EMPTY   = 2'd0,
        LVL_PARTIAL = 2'd1,
        LVL_FULL    = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        SEL_TOS_UP = 2'd0,
        SEL_TOS_HI = 2'd1,
        SEL_TOS_LO = 2'd2,
        SEL_PTR    = 2'd3
    } sel_e;

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int unsigned DEPTH = 31,
    parameter int unsigned PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             sw_any_wr,
    input  logic             sw_ptr_wr,
    input  logic [PTR_W-1:0] sw_ptr_val,
    input  logic             sw_keep_ovf,
    input  logic             sw_keep_unf,
    output logic [PTR_W-1:0] ptr_q,
    output logic             push_go,
    output logic             full,
    output logic             empty,
    output logic             ovf_q,
    output logic             unf_q
);

    localparam logic [PTR_W-1:0] TOP_P  = PTR_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] ONE_P  = PTR_W'(1);

    lvl_e             state_q, state_d;
    logic [PTR_W-1:0] ptr_d, ptr_ld;
    logic             push_ovf, pop_act, pop_go, pop_unf;

    function automatic lvl_e lvl_of(input logic [PTR_W-1:0] p);
        if (p == '0)
            return LVL_EMPTY;
        else if (p == TOP_P)
            return LVL_FULL;
        else
            return LVL_PARTIAL;
    endfunction

    // Request qualification: software access beats push, push beats pop
    always_comb begin
        push_go  = push_req && !sw_any_wr && (ptr_q != TOP_P);
        push_ovf = push_req && !sw_any_wr && (ptr_q == TOP_P);
        pop_act  = pop_req && !push_req && !sw_any_wr;
        pop_go   = pop_act && (ptr_q != '0);
        pop_unf  = pop_act && (ptr_q == '0);
        ptr_ld   = (sw_ptr_val > TOP_P) ? TOP_P : sw_ptr_val;
    end

    always_comb begin
        ptr_d = ptr_q;
        if (sw_ptr_wr)
            ptr_d = ptr_ld;
        else if (push_go)
            ptr_d = ptr_q + ONE_P;
        else if (pop_go)
            ptr_d = ptr_q - ONE_P;
    end

    // Level state machine: next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_EMPTY: begin
                if (sw_ptr_wr)
                    state_d = lvl_of(ptr_ld);
                else if (push_go)
                    state_d = LVL_PARTIAL;
            end
            LVL_PARTIAL: begin
                if (sw_ptr_wr)
                    state_d = lvl_of(ptr_ld);
                else if (push_go && ptr_q == LAST_P)
                    state_d = LVL_FULL;
                else if (pop_go && ptr_q == ONE_P)
                    state_d = LVL_EMPTY;
            end
            LVL_FULL: begin
                if (sw_ptr_wr)
                    state_d = lvl_of(ptr_ld);
                else if (pop_go)
                    state_d = LVL_PARTIAL;
            end
            default: state_d = LVL_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LVL_EMPTY;
        else
            state_q <= state_d;
    end

    // Pointer and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ptr_q <= ptr_d;
            if (sw_ptr_wr) begin
                ovf_q <= ovf_q & sw_keep_ovf;
                unf_q <= unf_q & sw_keep_unf;
            end else begin
                ovf_q <= ovf_q | push_ovf;
                unf_q <= unf_q | pop_unf;
            end
        end
    end

    // Outputs from state
    always_comb begin
        full  = (state_q == LVL_FULL);
        empty = (state_q == LVL_EMPTY);
    end

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int unsigned DEPTH = 31,
    parameter int unsigned PTR_W = 5,
    parameter int unsigned PC_W  = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] widx,
    input  logic [PC_W-1:0]  wdata,
    input  logic [PTR_W-1:0] ridx,
    output logic [PC_W-1:0]  rdata
);

    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] TOP_P = PTR_W'(DEPTH);

    logic [PC_W-1:0] mem_q [DEPTH];
    logic            w_ok, r_ok;

    // Pointer value p maps to slot p-1; value 0 has no slot
    assign w_ok = we && (widx != '0) && (widx <= TOP_P);
    assign r_ok = (ridx != '0) && (ridx <= TOP_P);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(DEPTH); k++)
                mem_q[k] <= '0;
        end else if (w_ok) begin
            mem_q[IDX_W'(widx - 1'b1)] <= wdata;
        end
    end

    assign rdata = r_ok ? mem_q[IDX_W'(ridx - 1'b1)] : '0;

endmodule

// File: rtl/ras_swif.sv
module ras_swif
    import ras_pkg::*;
#(
    parameter int unsigned PTR_W = 5,
    parameter int unsigned PC_W  = 21
) (
    input  logic [1:0]       sw_sel,
    input  logic             sw_wr,
    input  logic [7:0]       sw_wdata,
    input  logic [PC_W-1:0]  tos,
    input  logic             tos_valid,
    input  logic [PTR_W-1:0] ptr,
    input  logic             full,
    input  logic             ovf,
    input  logic             unf,
    output logic [7:0]       sw_rdata,
    output logic             tos_wr,
    output logic [PC_W-1:0]  tos_new,
    output logic             ptr_wr
);

    localparam int unsigned UP_W = PC_W - 16;

    sel_e sel;
    assign sel = sel_e'(sw_sel);

    always_comb begin
        sw_rdata = 8'h00;
        unique case (sel)
            SEL_TOS_UP: sw_rdata = tos_valid ? 8'(tos[PC_W-1:16]) : 8'h00;
            SEL_TOS_HI: sw_rdata = tos_valid ? tos[15:8] : 8'h00;
            SEL_TOS_LO: sw_rdata = tos_valid ? tos[7:0]  : 8'h00;
            SEL_PTR:    sw_rdata = {ovf, unf, full, 5'(ptr)};
            default:    sw_rdata = 8'h00;
        endcase
    end

    always_comb begin
        tos_new = tos;
        unique case (sel)
            SEL_TOS_UP: tos_new = {sw_wdata[UP_W-1:0], tos[15:0]};
            SEL_TOS_HI: tos_new = {tos[PC_W-1:16], sw_wdata, tos[7:0]};
            SEL_TOS_LO: tos_new = {tos[PC_W-1:8], sw_wdata};
            SEL_PTR:    tos_new = tos;
            default:    tos_new = tos;
        endcase
    end

    assign ptr_wr = sw_wr && (sel == SEL_PTR);
    assign tos_wr = sw_wr && (sel != SEL_PTR) && tos_valid;

endmodule

// File: rtl/ras_unit.sv
module ras_unit
    import ras_pkg::*;
#(
    parameter int unsigned DEPTH = 31,
    parameter int unsigned PTR_W = 5,
    parameter int unsigned PC_W  = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_req,
    input  logic [PC_W-1:0] push_pc,
    input  logic            pop_req,
    output logic [PC_W-1:0] pop_pc,
    input  logic [1:0]      sw_sel,
    input  logic            sw_wr,
    input  logic [7:0]      sw_wdata,
    output logic [7:0]      sw_rdata,
    output logic            stk_full,
    output logic            stk_ovf,
    output logic            stk_unf
);

    logic [PTR_W-1:0] ptr_q;
    logic             push_go, full, empty, ovf_q, unf_q;
    logic             tos_wr, ptr_wr;
    logic [PC_W-1:0]  tos, tos_new, mem_wdata;
    logic [PTR_W-1:0] mem_widx;
    logic             mem_we;

    ras_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_req    (push_req),
        .pop_req     (pop_req),
        .sw_any_wr   (sw_wr),
        .sw_ptr_wr   (ptr_wr),
        .sw_ptr_val  (sw_wdata[PTR_W-1:0]),
        .sw_keep_ovf (sw_wdata[7]),
        .sw_keep_unf (sw_wdata[6]),
        .ptr_q       (ptr_q),
        .push_go     (push_go),
        .full        (full),
        .empty       (empty),
        .ovf_q       (ovf_q),
        .unf_q       (unf_q)
    );

    // Single write port: push target slot, or top entry for software
    always_comb begin
        mem_we    = push_go || tos_wr;
        mem_widx  = push_go ? ptr_q + PTR_W'(1) : ptr_q;
        mem_wdata = push_go ? push_pc : tos_new;
    end

    ras_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .PC_W(PC_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .widx  (mem_widx),
        .wdata (mem_wdata),
        .ridx  (ptr_q),
        .rdata (tos)
    );

    ras_swif #(.PTR_W(PTR_W), .PC_W(PC_W)) u_swif (
        .sw_sel    (sw_sel),
        .sw_wr     (sw_wr),
        .sw_wdata  (sw_wdata),
        .tos       (tos),
        .tos_valid (!empty),
        .ptr       (ptr_q),
        .full      (full),
        .ovf       (ovf_q),
        .unf       (unf_q),
        .sw_rdata  (sw_rdata),
        .tos_wr    (tos_wr),
        .tos_new   (tos_new),
        .ptr_wr    (ptr_wr)
    );

    assign pop_pc   = tos;
    assign stk_full = full;
    assign stk_ovf  = ovf_q;
    assign stk_unf  = unf_q;

endmodule

// File: rtl/ras_unit_chk.sv
module ras_unit_chk #(
    parameter int unsigned DEPTH = 31,
    parameter int unsigned PTR_W = 5,
    parameter int unsigned PC_W  = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_req,
    input logic             pop_req,
    input logic             sw_wr,
    input logic [1:0]       sw_sel,
    input logic [7:0]       sw_rdata,
    input logic [PC_W-1:0]  pop_pc,
    input logic [PTR_W-1:0] ptr,
    input logic             full,
    input logic             ovf,
    input logic             unf
);

    localparam logic [PTR_W-1:0] TOP_P = PTR_W'(DEPTH);

    p_push_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !sw_wr && ptr != TOP_P) |=> (ptr == $past(ptr) + PTR_W'(1)));

    p_pop_decr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !sw_wr && ptr != '0) |=> (ptr == $past(ptr) - PTR_W'(1)));

    p_full_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full == (ptr == TOP_P));

    p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && !sw_wr && ptr == TOP_P) |=> (ovf && ptr == TOP_P));

    p_unf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && !sw_wr && ptr == '0) |=> (unf && ptr == '0));

    p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == '0) |-> (pop_pc == '0));

    p_slot0_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == '0 && sw_sel != 2'd3) |-> (sw_rdata == 8'h00));

    p_sticky_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(sw_wr && sw_sel == 2'd3)) |=> ovf);

    p_sticky_unf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (unf && !(sw_wr && sw_sel == 2'd3)) |=> unf);

endmodule

bind ras_unit ras_unit_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W), .PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_req),
    .pop_req  (pop_req),
    .sw_wr    (sw_wr),
    .sw_sel   (sw_sel),
    .sw_rdata (sw_rdata),
    .pop_pc   (pop_pc),
    .ptr      (ptr_q),
    .full     (full),
    .ovf      (ovf_q),
    .unf      (unf_q)
);

// File: tb/ras_unit_tb.sv
module ras_unit_tb;

    localparam int DEPTH = 31;
    localparam int PC_W  = 21;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            push_req = 1'b0;
    logic [PC_W-1:0] push_pc = '0;
    logic            pop_req = 1'b0;
    logic [PC_W-1:0] pop_pc;
    logic [1:0]      sw_sel = 2'd0;
    logic            sw_wr = 1'b0;
    logic [7:0]      sw_wdata = 8'h00;
    logic [7:0]      sw_rdata;
    logic            stk_full, stk_ovf, stk_unf;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model of the stack, updated from the requirements
    logic [PC_W-1:0] mdl [0:DEPTH];
    int              mptr = 0;
    logic            movf = 1'b0;
    logic            munf = 1'b0;
    logic [PC_W-1:0] exp_q [$];

    always #4 clk = ~clk;

    ras_unit u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .push_pc  (push_pc),
        .pop_req  (pop_req),
        .pop_pc   (pop_pc),
        .sw_sel   (sw_sel),
        .sw_wr    (sw_wr),
        .sw_wdata (sw_wdata),
        .sw_rdata (sw_rdata),
        .stk_full (stk_full),
        .stk_ovf  (stk_ovf),
        .stk_unf  (stk_unf)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PC_W-1:0] pat(input int i);
        return PC_W'((i * 24'h0A3F5) ^ 24'h15A5A7);
    endfunction

    // Driver: one clock of stimulus, model update, expected pop queued
    task automatic op(input logic ps, input logic [PC_W-1:0] pc, input logic pp,
                      input logic w, input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        push_req = ps; push_pc = pc; pop_req = pp;
        sw_wr = w; sw_sel = s; sw_wdata = d;
        if (pp && !ps && !w)
            exp_q.push_back((mptr == 0) ? '0 : mdl[mptr]);
        @(posedge clk);
        #1;
        push_req = 1'b0; pop_req = 1'b0; sw_wr = 1'b0;
        if (w) begin
            if (s == 2'd3) begin
                mptr = int'(d[4:0]);
                movf = movf & d[7];
                munf = munf & d[6];
            end else if (mptr != 0) begin
                case (s)
                    2'd0: mdl[mptr][20:16] = d[4:0];
                    2'd1: mdl[mptr][15:8]  = d;
                    default: mdl[mptr][7:0] = d;
                endcase
            end
        end else if (ps) begin
            if (mptr == DEPTH) movf = 1'b1;
            else begin mptr++; mdl[mptr] = pc; end
        end else if (pp) begin
            if (mptr == 0) munf = 1'b1;
            else mptr--;
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [7:0] v);
        sw_sel = s;
        #1;
        v = sw_rdata;
    endtask

    task automatic chk_state(input string tag);
        logic [7:0] v;
        rd(2'd3, v);
        chk({tag, " status"}, v, {movf, munf, (mptr == DEPTH), 5'(mptr)});
        chk({tag, " full pin"}, stk_full, (mptr == DEPTH));
        chk({tag, " ovf pin"}, stk_ovf, movf);
        chk({tag, " unf pin"}, stk_unf, munf);
    endtask

    task automatic chk_tos(input string tag);
        logic [7:0] v;
        logic [PC_W-1:0] e;
        e = (mptr == 0) ? '0 : mdl[mptr];
        rd(2'd0, v); chk({tag, " upper"}, v, {3'b000, e[20:16]});
        rd(2'd1, v); chk({tag, " high"}, v, e[15:8]);
        rd(2'd2, v); chk({tag, " low"}, v, e[7:0]);
    endtask

    // Monitor: compares restore address of each accepted pop
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (pop_req && !push_req && !sw_wr) begin
                if (exp_q.size() == 0) begin
                    chk("R3 unexpected pop", 1, 0);
                end else begin
                    logic [PC_W-1:0] e;
                    e = exp_q.pop_front();
                    chk((e == '0 && mptr == 0) ? "R8 pop_pc" : "R3 pop_pc", pop_pc, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i <= DEPTH; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R9 slot 0 reads zero and ignores writes
        chk_state("R1 reset");
        chk_tos("R9 empty");
        op(0, '0, 0, 1, 2'd2, 8'h55);
        rd(2'd2, v); chk("R9 ignored write", v, 8'h00);
        chk_state("R9 after write");

        // R2 nested pushes, R4 field views
        for (int i = 1; i <= 3; i++) begin
            op(1, pat(i), 0, 0, 2'd0, 8'h00);
            chk_state("R2 push");
            chk_tos("R4 after push");
        end

        // R3 pop
        op(0, '0, 1, 0, 2'd0, 8'h00);
        chk_state("R3 after pop");

        // R4 field writes then pop the edited entry
        op(0, '0, 0, 1, 2'd0, 8'h1F);
        op(0, '0, 0, 1, 2'd1, 8'hAB);
        op(0, '0, 0, 1, 2'd2, 8'hCD);
        chk_tos("R4 edited");
        op(0, '0, 1, 0, 2'd0, 8'h00);
        chk_state("R4 pop edited");

        // R10 push beats pop; software write beats push
        op(1, pat(40), 1, 0, 2'd0, 8'h00);
        chk_state("R10 push over pop");
        chk_tos("R10 push over pop");
        op(1, pat(41), 0, 1, 2'd3, 8'hC2);
        chk_state("R10 write over push");
        op(0, '0, 1, 1, 2'd2, 8'h77);
        chk_state("R10 write over pop");
        chk_tos("R10 write over pop");

        // R6 fill to full, R7 overflow
        while (mptr < DEPTH) op(1, pat(100 + mptr), 0, 0, 2'd0, 8'h00);
        chk_state("R6 full");
        op(1, 21'h1FFFFF, 0, 0, 2'd0, 8'h00);
        chk_state("R7 overflow");
        chk_tos("R7 entries kept");

        // R11 sticky until cleared through select 3
        op(0, '0, 1, 0, 2'd0, 8'h00);
        chk_state("R11 ovf after pop");
        op(0, '0, 0, 1, 2'd3, 8'h9E);
        chk_state("R11 keep ovf");
        op(0, '0, 0, 1, 2'd3, 8'h1E);
        chk_state("R11 clear ovf");

        // Drain, then R8 underflow twice
        while (mptr > 0) op(0, '0, 1, 0, 2'd0, 8'h00);
        chk_state("R8 drained");
        op(0, '0, 1, 0, 2'd0, 8'h00);
        chk_state("R8 underflow");
        op(0, '0, 1, 0, 2'd0, 8'h00);
        chk_state("R8 underflow again");

        // R5 pointer load exposes a retained entry; R11 clear underflow
        op(0, '0, 0, 1, 2'd3, 8'h45);
        chk_state("R5 ptr load keep unf");
        chk_tos("R5 ptr load");
        op(0, '0, 0, 1, 2'd3, 8'h05);
        chk_state("R11 clear unf");
        op(0, '0, 1, 0, 2'd0, 8'h00);
        chk_state("R5 pop after load");

        repeat (3) @(negedge clk);
        chk("R3 queue drained", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule